// File: doc/BRIEF.md
# Reduced Picture-Processor Register Front End

This block is the processor-facing register file of a cut-down picture processor. A byte-wide CPU bus selects one of eight register slots through a 3-bit index. The block filters some writes, drops others and redirects others. It keeps the control byte, the horizontal scroll value and the 16-bit video memory address. It also holds a 256-byte sprite attribute store, which the CPU fills through a single auto-incrementing port.

A shared first/second write flag is used by both the scroll slot and the address slot. A write to the address slot never changes the scroll values. Every second scroll write is forced to zero, so the vertical scroll stays at zero. The status slot does not report real sprite collisions. Its flag bit depends only on which scanline window the rest of the processor reports on its scanline input.

Reads are registered. The read data appears on the clock edge that samples the read strobe and is held until the next read. Pixel generation and the video memory data slot are handled elsewhere.

Top module: `ppu_regfile_lite`

## Requirements
- R1: After reset, the control byte is 0x10, both scroll outputs and the video address are zero, the sprite address is zero, read data is zero, and the next scroll or address write is treated as a first write.
- R2: A write to slot 0 stores only data bits 0, 2 and 7. Bit 4 is always forced to 1 and every other bit reads as 0.
- R3: Writes to slot 1 and slot 3 change no output and no state: not the control byte, the scroll values, the video address or the sprite address.
- R4: A write to slot 4 issues one sprite write command (`spr_we` high during that cycle) at the current sprite address with the written byte. The sprite address then advances by one and wraps from 255 to 0.
- R5: Slot 5 uses the shared write flag. A first write loads `scroll_x`. A second write stores zero into `scroll_y` whatever the data is. Neither write changes the video address.
- R6: Slot 6 uses the same flag. A first write loads address bits 15:8 and a second write loads bits 7:0. Neither write changes `scroll_x` or `scroll_y`. A slot-5 write followed by a slot-6 write makes the slot-6 write a second write.
- R7: A read of slot 2 returns 0xBF (bit 6 clear) when the scanline is below 31 or at least 239, and returns 0xFF otherwise.
- R8: A read of slot 4 returns the stored sprite byte at the current sprite address and does not advance that address.
- R9: `ctrl1_q` is always 0x1E: background and sprites enabled, monochrome (bit 0) and emphasis (bits 7:5) off.
- R10: `nmi_en` follows control bit 7 and `addr_inc32` follows control bit 2.
- R11: Reads of slots 0, 1, 3, 5, 6 and 7 return 0x00. Read data changes only on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register slot index (CPU address bits 2:0) |
| rd_en | input | 1 | Read strobe, one cycle |
| wr_en | input | 1 | Write strobe, one cycle |
| wr_data | input | 8 | Write data |
| scanline | input | 9 | Current scanline number |
| rd_data | output | 8 | Registered read data |
| ctrl0_q | output | 8 | Filtered control byte |
| ctrl1_q | output | 8 | Fixed display control byte |
| nmi_en | output | 1 | Vertical blank interrupt enable |
| addr_inc32 | output | 1 | Address step select |
| scroll_x | output | 8 | Horizontal scroll |
| scroll_y | output | 8 | Vertical scroll (forced zero) |
| vram_addr | output | 16 | Video memory address |
| spr_we | output | 1 | Sprite write command |
| spr_waddr | output | 8 | Current sprite address |
| spr_wdata | output | 8 | Sprite write byte |

## Verification
The assertions take for granted that the CPU never raises `rd_en` and `wr_en` in the same cycle and that each strobe lasts one cycle. One property checks that the two strobes never overlap. The bench drives every access from a task that raises exactly one strobe for one cycle and lowers it before the next access. The scanline input is held steady around each status read, so the sampled window is unambiguous.

// File: rtl/ppu_regfile_lite.sv
module ppu_regfile_lite #(
  parameter int SCAN_W     = 9,
  parameter int SPLIT_LINE = 31,
  parameter int BLANK_LINE = 239,
  parameter int SPR_DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic [SCAN_W-1:0] scanline,
  output logic [7:0]        rd_data,
  output logic [7:0]        ctrl0_q,
  output logic [7:0]        ctrl1_q,
  output logic              nmi_en,
  output logic              addr_inc32,
  output logic [7:0]        scroll_x,
  output logic [7:0]        scroll_y,
  output logic [15:0]       vram_addr,
  output logic              spr_we,
  output logic [7:0]        spr_waddr,
  output logic [7:0]        spr_wdata
);
  localparam int SPR_AW = $clog2(SPR_DEPTH);
  localparam logic [SCAN_W-1:0] SPLIT_L = SCAN_W'(SPLIT_LINE);
  localparam logic [SCAN_W-1:0] BLANK_L = SCAN_W'(BLANK_LINE);
  localparam logic [7:0] KEEP_MASK  = 8'h85;
  localparam logic [7:0] FORCE_BITS = 8'h10;
  localparam logic [7:0] CTRL1_FIX  = 8'h1E;
  localparam logic [7:0] STAT_HIT   = 8'hFF;
  localparam logic [7:0] STAT_MISS  = 8'hBF;

  logic [7:0]        spr_mem [SPR_DEPTH];
  logic [SPR_AW-1:0] spr_addr;
  logic              second_wr;

  wire sel_ctrl  = reg_sel == 3'd0;
  wire sel_stat  = reg_sel == 3'd2;
  wire sel_spr   = reg_sel == 3'd4;
  wire sel_scrl  = reg_sel == 3'd5;
  wire sel_addr  = reg_sel == 3'd6;
  wire in_window = (scanline < SPLIT_L) || (scanline >= BLANK_L);

  assign ctrl1_q    = CTRL1_FIX;
  assign nmi_en     = ctrl0_q[7];
  assign addr_inc32 = ctrl0_q[2];
  assign spr_we     = wr_en && sel_spr;
  assign spr_waddr  = 8'(spr_addr);
  assign spr_wdata  = wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl0_q   <= FORCE_BITS;
      scroll_x  <= '0;
      scroll_y  <= '0;
      vram_addr <= '0;
      spr_addr  <= '0;
      second_wr <= 1'b0;
      rd_data   <= '0;
    end else if (wr_en) begin
      if (sel_ctrl) ctrl0_q <= (wr_data & KEEP_MASK) | FORCE_BITS;
      if (sel_spr)  spr_addr <= spr_addr + 1'b1;
      if (sel_scrl) begin
        if (second_wr) scroll_y <= '0;
        else           scroll_x <= wr_data;
        second_wr <= ~second_wr;
      end
      if (sel_addr) begin
        if (second_wr) vram_addr[7:0]  <= wr_data;
        else           vram_addr[15:8] <= wr_data;
        second_wr <= ~second_wr;
      end
    end else if (rd_en) begin
      if (sel_stat)     rd_data <= in_window ? STAT_MISS : STAT_HIT;
      else if (sel_spr) rd_data <= spr_mem[spr_addr];
      else              rd_data <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (spr_we) spr_mem[spr_addr] <= wr_data;
  end

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  p_ctrl_filter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 3'd0) |=> ctrl0_q == (($past(wr_data) & 8'h85) | 8'h10));

  p_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (reg_sel == 3'd1 || reg_sel == 3'd3)) |=>
      $stable(ctrl0_q) && $stable(vram_addr) && $stable(spr_waddr) && $stable(scroll_x));

  p_spr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spr_we |=> spr_waddr == 8'($past(spr_waddr) + 8'd1));

  p_scroll_keeps_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 3'd5) |=> $stable(vram_addr) && scroll_y == 8'h00);

  p_addr_keeps_scroll_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 3'd6) |=> $stable(scroll_x) && $stable(scroll_y));

  p_status_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel == 3'd2) |=> (rd_data[6] == ($past(scanline) >= 9'd31 && $past(scanline) < 9'd239)));

  p_spr_read_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_sel == 3'd4) |=> $stable(spr_waddr));
endmodule

// File: tb/ppu_regfile_lite_tb.sv
module ppu_regfile_lite_tb;
  logic clk = 0, rst_n = 0, rd_en = 0, wr_en = 0;
  logic [2:0] reg_sel = 0;
  logic [7:0] wr_data = 0;
  logic [8:0] scanline = 0;
  logic [7:0] rd_data, ctrl0_q, ctrl1_q, scroll_x, scroll_y, spr_waddr, spr_wdata;
  logic nmi_en, addr_inc32, spr_we;
  logic [15:0] vram_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ppu_regfile_lite u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .scanline(scanline), .rd_data(rd_data), .ctrl0_q(ctrl0_q),
    .ctrl1_q(ctrl1_q), .nmi_en(nmi_en), .addr_inc32(addr_inc32), .scroll_x(scroll_x),
    .scroll_y(scroll_y), .vram_addr(vram_addr), .spr_we(spr_we), .spr_waddr(spr_waddr),
    .spr_wdata(spr_wdata));

  localparam logic [16:0] STAT_VEC [8] = '{
    {9'd0, 8'hBF}, {9'd30, 8'hBF}, {9'd31, 8'hFF}, {9'd100, 8'hFF},
    {9'd238, 8'hFF}, {9'd239, 8'hBF}, {9'd279, 8'hBF}, {9'd32, 8'hFF}};

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] s, logic [7:0] d);
    @(negedge clk); reg_sel = s; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic spr_write(logic [7:0] d, logic [7:0] exp_addr, bit chk);
    @(negedge clk); reg_sel = 3'd4; wr_data = d; wr_en = 1;
    #1;
    if (chk) begin
      check("R4 we", {15'd0, spr_we}, 16'd1);
      check("R4 addr", {8'd0, spr_waddr}, {8'd0, exp_addr});
      check("R4 data", {8'd0, spr_wdata}, {8'd0, d});
    end
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] s, output logic [7:0] v);
    @(negedge clk); reg_sel = s; rd_en = 1;
    @(negedge clk); rd_en = 0; v = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    do_reset();
    check("R1 ctrl0", {8'd0, ctrl0_q}, 16'h0010);
    check("R1 scroll", {scroll_x, scroll_y}, 16'h0000);
    check("R1 vram", vram_addr, 16'h0000);
    check("R1 spr addr", {8'd0, spr_waddr}, 16'h0000);
    check("R1 rd_data", {8'd0, rd_data}, 16'h0000);
    check("R9 ctrl1", {8'd0, ctrl1_q}, 16'h001E);

    for (int i = 0; i < 8; i++) begin
      scanline = STAT_VEC[i][16:8];
      rd(3'd2, v);
      check("R7 status", {7'd0, scanline}, {7'd0, scanline});
      check("R7 status", {8'd0, v}, {8'd0, STAT_VEC[i][7:0]});
    end
    scanline = 9'd100;

    wr(3'd0, 8'hFF);
    check("R2 ctrl0 mask", {8'd0, ctrl0_q}, 16'h0095);
    check("R10 flags", {14'd0, nmi_en, addr_inc32}, 16'd3);
    wr(3'd0, 8'h7A);
    check("R2 ctrl0 mask", {8'd0, ctrl0_q}, 16'h0010);
    check("R10 flags", {14'd0, nmi_en, addr_inc32}, 16'd0);
    wr(3'd0, 8'h04);
    check("R10 inc only", {14'd0, nmi_en, addr_inc32}, 16'd1);

    wr(3'd1, 8'hAA);
    wr(3'd3, 8'h55);
    check("R3 ctrl0", {8'd0, ctrl0_q}, 16'h0014);
    check("R3 spr addr", {8'd0, spr_waddr}, 16'h0000);
    check("R3 vram", vram_addr, 16'h0000);
    check("R9 ctrl1 after write", {8'd0, ctrl1_q}, 16'h001E);

    spr_write(8'h11, 8'd0, 1);
    spr_write(8'h22, 8'd1, 1);
    check("R4 step", {8'd0, spr_waddr}, 16'd2);
    for (int i = 2; i < 256; i++) spr_write(8'(i) ^ 8'h5A, 8'(i), 0);
    check("R4 wrap", {8'd0, spr_waddr}, 16'd0);
    rd(3'd4, v);
    check("R8 read", {8'd0, v}, 16'h0011);
    rd(3'd4, v);
    check("R8 no step", {8'd0, v}, 16'h0011);
    check("R8 addr held", {8'd0, spr_waddr}, 16'd0);
    spr_write(8'h77, 8'd0, 1);
    rd(3'd4, v);
    check("R8 next byte", {8'd0, v}, 16'h0022);

    wr(3'd5, 8'h34);
    check("R5 first", {8'd0, scroll_x}, 16'h0034);
    wr(3'd5, 8'h99);
    check("R5 second zero", {scroll_x, scroll_y}, 16'h3400);
    check("R5 vram kept", vram_addr, 16'h0000);

    wr(3'd6, 8'h21);
    wr(3'd6, 8'h08);
    check("R6 address", vram_addr, 16'h2108);
    check("R6 scroll kept", {scroll_x, scroll_y}, 16'h3400);
    wr(3'd5, 8'h56);
    wr(3'd6, 8'h3C);
    check("R6 shared flag", vram_addr, 16'h213C);
    check("R6 scroll x", {8'd0, scroll_x}, 16'h0056);

    rd(3'd0, v); check("R11 slot0", {8'd0, v}, 16'h0000);
    rd(3'd7, v); check("R11 slot7", {8'd0, v}, 16'h0000);
    rd(3'd2, v);
    wr(3'd0, 8'h80);
    check("R11 hold", {8'd0, rd_data}, 16'h00FF);

    wr(3'd6, 8'h12);
    do_reset();
    check("R1 reset ctrl0", {8'd0, ctrl0_q}, 16'h0010);
    wr(3'd6, 8'h40);
    wr(3'd6, 8'h05);
    check("R1 flag cleared", vram_addr, 16'h4005);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule